// File: doc/BRIEF.md
# DTMF Digit Steering Validator

This block sits behind a dual-tone detector and decides when a detected tone pair counts as a keyed digit. The detector supplies a level that is high while it sees a valid pair, together with the 4-bit code of that pair. The validator makes that level prove itself twice. The tone must stay present for a programmable number of timing ticks before its code is captured. The silence that follows must then last a second programmable number of ticks before the digit is treated as finished.

Because of this two-sided check, a brief burst during a pause never becomes a digit, and a brief dropout during a key press never splits one digit into two. The shortest tone the system accepts is the detector's own reaction delay plus the tone-present guard time.

When a digit is accepted, a guard output rises on the same edge that loads the output latch. A delayed steering strobe follows a fixed number of clock cycles later, once the latch has settled. A downstream controller waits for the strobe and then reads the code through an output-enable gated bus. Both guard times are runtime inputs, counted in cycles of a tick enable, so one design serves different clock rates and immunity targets.

Top module: `dtmf_steer_validator`

## Requirements
- R1: With `tick_en` high every cycle and `present_lim` = P (P at least 1), a tone sampled high on P+1 consecutive rising edges is registered on the last of those edges. A tone lasting only P edges is discarded and leaves the latch untouched, so short bursts during a pause are ignored.
- R2: On the registering edge, `tone_code` is captured into the output latch and `guard` rises.
- R3: `guard` stays high for as long as `tone_valid` stays high after registration.
- R4: `strobe` rises exactly SETTLE clock cycles after `guard` rises (default SETTLE = 2). Every registered digit produces exactly one strobe.
- R5: A gap in `tone_valid` shorter than the tone-absent guard does not end the digit. When the tone returns after such a gap, the latch is not reloaded even if the code has changed, and no second strobe is produced.
- R6: With `absent_lim` = A (A at least 1), a digit ends on the edge where `tone_valid` has been sampled low on A+1 consecutive edges, provided the strobe is already high. `guard` and `strobe` fall together on that edge and not before it.
- R7: While `oe` is high, `bus_drive` is 1 and `code_bus` carries the latched code. While `oe` is low, `bus_drive` is 0 and `code_bus` reads 0000.
- R8: The guard counters advance only in cycles where `tick_en` is high. A tone held for any length of time with no ticks is never registered.
- R9: `present_lim` and `absent_lim` may be changed while the block runs, and a new value governs the next count.
- R10: The latch stores the 4-bit code exactly as presented. The key assignment is: 0001 to 1001 for keys 1 to 9, 1010 for key 0, 1011 for star, 1100 for hash, 1101 to 1111 for letters A to C, and 0000 for letter D.
- R11: `rst_n` low clears the latch to 0000, drops `guard` and `strobe` at once, and returns the block to the idle, tone-absent state. Release takes effect synchronously two clock edges later.
- R12: After a digit ends, the latch keeps the last registered code until the next registration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| tick_en | input | 1 | Timing tick; guard counters advance only when high |
| tone_valid | input | 1 | Early steering level from the tone detector |
| tone_code | input | 4 | Code of the tone pair currently detected |
| present_lim | input | CNT_W | Tone-present guard time in ticks |
| absent_lim | input | CNT_W | Tone-absent guard time in ticks |
| oe | input | 1 | Output enable for the code bus |
| code_bus | output | 4 | Latched code while enabled, zero otherwise |
| bus_drive | output | 1 | High while the code bus is driven |
| guard | output | 1 | High from registration until the digit ends |
| strobe | output | 1 | Delayed steering strobe: a digit is ready to read |

## Verification
The hardest state to reach is a dropout that returns carrying a different code while the digit is still held. The first code must survive, and no second strobe may appear. The stimulus holds a tone well past registration and opens a gap of fewer than A+1 low edges. It then restarts the tone with a new code and checks that the bus still shows the first code, while the scoreboard rejects any extra strobe. A second hard case is a tone that lasts a long time without any tick. The stimulus holds the tick enable low for tens of cycles and confirms that nothing registers, then restarts the ticks and confirms that the same held tone now registers.

// File: rtl/dtmf_steer_pkg.sv
`timescale 1ns/1ps
package dtmf_steer_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no digit, tone absent
    ST_ACQ  = 2'd1,  // tone seen, qualifying its duration
    ST_HELD = 2'd2,  // digit registered, tone present
    ST_REL  = 2'd3   // digit registered, qualifying the pause
  } steer_state_t;
endpackage

// File: rtl/dtmf_rst_sync.sv
`timescale 1ns/1ps
module dtmf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dtmf_guard_fsm.sv
`timescale 1ns/1ps
module dtmf_guard_fsm
  import dtmf_steer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             tone_i,
  input  logic [CNT_W-1:0] present_lim,
  input  logic [CNT_W-1:0] absent_lim,
  input  logic             strobe_i,
  output logic             load_o,
  output logic             end_o,
  output logic             digit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  steer_state_t     st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_step;

  assign cnt_step = tick_en && (cnt_q != CNT_MAX);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    load_o = 1'b0;
    end_o  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (tone_i) begin
          st_n  = ST_ACQ;
          cnt_n = tick_en ? CNT_ONE : '0;
        end
      end
      ST_ACQ: begin
        if (!tone_i) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (cnt_q >= present_lim) begin
          st_n   = ST_HELD;
          cnt_n  = '0;
          load_o = 1'b1;
        end else if (cnt_step) begin
          cnt_n = cnt_q + CNT_ONE;
        end
      end
      ST_HELD: begin
        if (!tone_i) begin
          st_n  = ST_REL;
          cnt_n = tick_en ? CNT_ONE : '0;
        end
      end
      ST_REL: begin
        if (tone_i) begin
          st_n  = ST_HELD;
          cnt_n = '0;
        end else if ((cnt_q >= absent_lim) && strobe_i) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
          end_o = 1'b1;
        end else if (cnt_step) begin
          cnt_n = cnt_q + CNT_ONE;
        end
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  assign digit_o = (st_q == ST_HELD) || (st_q == ST_REL);

  // R1: a tone that vanishes while qualifying never yields a digit
  assert_short_tone_dropped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACQ && !tone_i) |=> !digit_o);

  // R3: guard is kept while the tone persists
  assert_guard_follows_tone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_o && tone_i) |=> digit_o);

  // R5: a returning tone during the pause resumes the same digit
  assert_dropout_resumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL && tone_i) |=> (st_q == ST_HELD));

  // R6: the digit cannot end before the strobe has been raised
  assert_end_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REL && !strobe_i) |=> (st_q != ST_IDLE));

  // R8: without a tick the qualifying count cannot complete
  assert_no_tick_no_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACQ && tone_i && !tick_en && (cnt_q < present_lim) && $stable(present_lim))
      |=> (st_q == ST_ACQ));
endmodule

// File: rtl/dtmf_settle.sv
`timescale 1ns/1ps
module dtmf_settle #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic end_i,
  input  logic digit_i,
  output logic strobe_o
);
  localparam int             SW          = $clog2(SETTLE + 1);
  localparam logic [SW-1:0]  SETTLE_LAST = SW'(SETTLE - 1);

  logic [SW-1:0] scnt_q, scnt_n;
  logic          strobe_n;

  always_comb begin
    scnt_n   = scnt_q;
    strobe_n = strobe_o;
    if (end_i || load_i) begin
      scnt_n   = '0;
      strobe_n = 1'b0;
    end else if (digit_i && !strobe_o) begin
      if (scnt_q == SETTLE_LAST) strobe_n = 1'b1;
      else                       scnt_n   = scnt_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q   <= '0;
      strobe_o <= 1'b0;
    end else begin
      scnt_q   <= scnt_n;
      strobe_o <= strobe_n;
    end
  end

  // R4: the strobe only exists while a digit is held
  assert_strobe_within_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> digit_i);

  // R6: once raised, the strobe stays until the digit ends
  assert_strobe_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o && !end_i) |=> strobe_o);
endmodule

// File: rtl/dtmf_code_latch.sv
`timescale 1ns/1ps
module dtmf_code_latch
  import dtmf_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              oe_i,
  output logic [CODE_W-1:0] bus_o,
  output logic              drv_o
);
  logic [CODE_W-1:0] code_q, code_n;

  always_comb begin
    code_n = code_q;
    if (load_i) code_n = code_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_n;
  end

  assign bus_o = oe_i ? code_q : '0;
  assign drv_o = oe_i;

  // R12: the stored code changes only on a registration
  assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(code_q));
endmodule

// File: rtl/dtmf_steer_validator.sv
`timescale 1ns/1ps
module dtmf_steer_validator
  import dtmf_steer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int SETTLE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              tone_valid,
  input  logic [CODE_W-1:0] tone_code,
  input  logic [CNT_W-1:0]  present_lim,
  input  logic [CNT_W-1:0]  absent_lim,
  input  logic              oe,
  output logic [CODE_W-1:0] code_bus,
  output logic              bus_drive,
  output logic              guard,
  output logic              strobe
);
  logic rst_s_n;
  logic load_w;
  logic end_w;
  logic digit_w;
  logic strobe_w;

  dtmf_rst_sync u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_s_n)
  );

  dtmf_guard_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .tick_en     (tick_en),
    .tone_i      (tone_valid),
    .present_lim (present_lim),
    .absent_lim  (absent_lim),
    .strobe_i    (strobe_w),
    .load_o      (load_w),
    .end_o       (end_w),
    .digit_o     (digit_w)
  );

  dtmf_settle #(.SETTLE(SETTLE)) u_settle (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_i   (load_w),
    .end_i    (end_w),
    .digit_i  (digit_w),
    .strobe_o (strobe_w)
  );

  dtmf_code_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .load_i (load_w),
    .code_i (tone_code),
    .oe_i   (oe),
    .bus_o  (code_bus),
    .drv_o  (bus_drive)
  );

  assign guard  = digit_w;
  assign strobe = strobe_w;
endmodule

// File: tb/tb_dtmf_steer_validator.sv
`timescale 1ns/1ps
module tb_dtmf_steer_validator;
  localparam int CNT_W = 8;

  logic             clk;
  logic             rst_n;
  logic             tick_en;
  logic             tone_valid;
  logic [3:0]       tone_code;
  logic [CNT_W-1:0] present_lim;
  logic [CNT_W-1:0] absent_lim;
  logic             oe;
  logic [3:0]       code_bus;
  logic             bus_drive;
  logic             guard;
  logic             strobe;

  int         checks;
  int         failures;
  logic [3:0] exp_q[$];
  logic       strobe_prev;
  bit         done;

  dtmf_steer_validator #(.CNT_W(CNT_W), .SETTLE(2)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tone_valid(tone_valid),
    .tone_code(tone_code), .present_lim(present_lim), .absent_lim(absent_lim),
    .oe(oe), .code_bus(code_bus), .bus_drive(bus_drive), .guard(guard), .strobe(strobe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe rise pops one expected code
  always @(negedge clk) begin
    if (strobe && !strobe_prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R5 unexpected strobe act=%0d exp=none", code_bus);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if (code_bus !== e) begin
          failures++;
          $display("FAIL R10 strobed code act=%0d exp=%0d", code_bus, e);
        end
      end
    end
    strobe_prev = strobe;
  end

  task automatic idle(input int n);
    tone_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // driver: one key press; the expectation follows R1 with tick every cycle
  task automatic press(input logic [3:0] code, input int high, input int low);
    if (high >= int'(present_lim) + 1) exp_q.push_back(code);
    tone_code  = code;
    tone_valid = 1'b1;
    repeat (high) @(negedge clk);
    idle(low);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0; strobe_prev = 1'b0;
    rst_n = 1'b0; tick_en = 1'b1; tone_valid = 1'b0; tone_code = 4'd0;
    present_lim = 8'd4; absent_lim = 8'd3; oe = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(guard == 1'b0 && strobe == 1'b0, "R11 reset outputs", guard + strobe, 0);
    chk(code_bus == 4'd0 && bus_drive, "R11 reset latch", code_bus, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R4: directed timing of one digit (P=4)
    exp_q.push_back(4'd5);
    tone_code = 4'd5; tone_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(guard == 1'b0, "R1 not yet registered at P edges", guard, 0);
    @(negedge clk);
    chk(guard == 1'b1, "R2 guard at P+1 edges", guard, 1);
    chk(code_bus == 4'd5, "R2 latch loaded", code_bus, 5);
    chk(strobe == 1'b0, "R4 strobe waits", strobe, 0);
    @(negedge clk);
    chk(strobe == 1'b0, "R4 strobe after 1 cycle", strobe, 0);
    @(negedge clk);
    chk(strobe == 1'b1, "R4 strobe after SETTLE cycles", strobe, 1);
    repeat (10) @(negedge clk);
    chk(guard == 1'b1, "R3 guard held with tone", guard, 1);
    // R6: end of digit after A+1 low edges (A=3)
    tone_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(guard && strobe, "R6 still held at A edges", guard + strobe, 2);
    @(negedge clk);
    chk(!guard && !strobe, "R6 ended at A+1 edges", guard + strobe, 0);
    chk(code_bus == 4'd5, "R12 latch keeps code", code_bus, 5);

    // R1: short burst in the pause is ignored and leaves the latch
    press(4'd9, 4, 10);
    chk(guard == 1'b0, "R1 short tone no guard", guard, 0);
    chk(code_bus == 4'd5, "R1 short tone latch untouched", code_bus, 5);

    // R5: dropout with a changed code keeps the first digit
    exp_q.push_back(4'd3);
    tone_code = 4'd3; tone_valid = 1'b1;
    repeat (8) @(negedge clk);
    idle(2);
    tone_code = 4'd7; tone_valid = 1'b1;
    repeat (6) @(negedge clk);
    chk(guard == 1'b1, "R5 dropout keeps guard", guard, 1);
    chk(code_bus == 4'd3, "R5 no relatch after dropout", code_bus, 3);
    idle(8);

    // R10: every code passes unchanged (1..9 -> 0001..1001, key0 1010,
    // star 1011, hash 1100, A..C 1101..1111, D 0000)
    for (int k = 0; k < 16; k++) press(4'(k), 7, 8);
    chk(code_bus == 4'hF, "R10 last code on bus", code_bus, 15);

    // R7: output enable gating
    oe = 1'b0;
    @(negedge clk);
    chk(code_bus == 4'd0 && !bus_drive, "R7 bus released", code_bus, 0);
    oe = 1'b1;
    @(negedge clk);
    chk(code_bus == 4'hF && bus_drive, "R7 bus driven", code_bus, 15);

    // R8: no ticks, no registration
    tick_en = 1'b0;
    exp_q.push_back(4'd2);
    tone_code = 4'd2; tone_valid = 1'b1;
    repeat (30) @(negedge clk);
    chk(guard == 1'b0, "R8 no tick no digit", guard, 0);
    tick_en = 1'b1;
    repeat (7) @(negedge clk);
    chk(guard == 1'b1, "R8 ticks resume count", guard, 1);
    idle(8);

    // R9: runtime limit changes
    present_lim = 8'd1;
    exp_q.push_back(4'hC);
    tone_code = 4'hC; tone_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(guard == 1'b1, "R9 shorter present limit", guard, 1);
    idle(10);
    absent_lim = 8'd1;
    exp_q.push_back(4'd4);
    tone_code = 4'd4; tone_valid = 1'b1;
    repeat (6) @(negedge clk);
    idle(1);
    tone_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(guard == 1'b1, "R9 one-edge gap is a dropout", guard, 1);
    tone_valid = 1'b0;
    @(negedge clk);
    chk(guard == 1'b1, "R9 held after one low edge", guard, 1);
    @(negedge clk);
    chk(guard == 1'b0, "R9 shorter absent limit", guard, 0);
    idle(4);

    // R11: reset during a held digit
    present_lim = 8'd4; absent_lim = 8'd3;
    exp_q.push_back(4'd8);
    tone_code = 4'd8; tone_valid = 1'b1;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!guard && !strobe && code_bus == 4'd0, "R11 async clear", code_bus + guard + strobe, 0);
    tone_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!guard && code_bus == 4'd0, "R11 idle after release", guard, 0);

    chk(exp_q.size() == 0, "R4 every digit strobed", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule